// File: doc/BRIEF.md
# Phase-Tagged Completion Ring Writer

This block is the device-side producer of a circular completion ring held in host memory. Each finished command arrives as a tag on a valid/ready stream. The block turns it into one 64-bit entry and writes that entry in a single beat to the next ring slot. The slot address is the ring base plus eight bytes per slot. The ring has no producer index. Bit 0 of every entry carries a phase flag instead. The host accepts an entry only while that bit matches the phase it expects, and it inverts its expectation each time it wraps. The writer starts with phase 1 over a zero-filled ring and inverts the phase it writes at every wrap.

A credit counter holds one credit per free slot. The host returns a credit with a one-cycle pulse for each entry it consumes. When no credit is left the writer stalls the tag stream instead of overwriting an unread entry. Every entry that lands in memory raises a pending bit behind an outbound doorbell. Software clears that bit explicitly. When message-signalled delivery is enabled, the bit clears itself once the interrupt has been signalled. A mask register and an interrupt status register gate and report the reply interrupt.

Top module: `cplq_ring_writer`

## Requirements
- R1: Each accepted tag produces exactly one memory write beat whose data holds the tag in bits 63:1 and the current phase in bit 0.
- R2: Slots are written in order 0, 1, …, SLOTS-1 and then 0 again, at address ring_base + 8 × slot. The phase is 1 on the first pass and inverts at every return to slot 0.
- R3: The credit count starts at SLOTS and each accepted tag consumes one credit. With no credit left, cpl_ready stays low. Each credit_ret pulse frees one slot, and a stalled tag is then accepted.
- R4: While mem_wvalid is high and mem_wready is low, mem_wvalid stays high and mem_waddr and mem_wdata hold their values.
- R5: Reading offset 0x9C returns bit 0 = 1 from the cycle after an entry write is accepted. After reset it reads 0.
- R6: A write to offset 0xA0 with bit 0 = 1 clears the pending bit. A write there with bit 0 = 0 leaves it unchanged.
- R7: The mask register at offset 0x34 resets to 0x05. Its bit 2 = 1 disables the interrupt, and writing 0 enables it. With message delivery off, irq equals the pending bit while the interrupt is enabled, and irq is low while it is disabled.
- R8: Reading offset 0x30 returns 0x04 while the pending bit is set and the interrupt is enabled, and 0 otherwise.
- R9: With msi_en high, an isolated completion raises irq for exactly one cycle, after which the pending bit reads 0. A completion that arrives while the interrupt is masked keeps the pending bit set, and the pulse is sent when the interrupt is unmasked.
- R10: When an entry write and a doorbell clear take effect in the same cycle, the pending bit ends up set.
- R11: After reset, cpl_ready is high, mem_wvalid is low and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msi_en | input | 1 | Message-signalled delivery enabled (auto-clear of the pending bit) |
| ring_base | input | ADDR_W | Byte address of ring slot 0, 8-byte aligned |
| cpl_valid | input | 1 | Completed tag is offered |
| cpl_ready | output | 1 | Tag is accepted this cycle |
| cpl_tag | input | 63 | Completed command tag |
| credit_ret | input | 1 | Host consumed one entry |
| mem_wvalid | output | 1 | Entry write request |
| mem_wready | input | 1 | Memory accepts the write |
| mem_waddr | output | ADDR_W | Entry byte address |
| mem_wdata | output | 64 | Entry data |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read enable |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational |
| irq | output | 1 | Reply interrupt: a level with message delivery off, a one-cycle pulse with it on |

## Verification
The assertions take for granted that the host never returns more credits than it has consumed. If it did, the credit count would exceed SLOTS. They also take for granted that msi_en only changes while no completion is pending. The bench returns exactly one credit per observed entry write, or a counted number of manual credits after the writes it has stalled. It switches msi_en only after it has cleared the doorbell and the ring has drained. Backpressure on the memory port comes from a fixed repeating pattern, so R4 holds on both sides.

// File: rtl/cplq_pkg.sv
package cplq_pkg;
    localparam int ENTRY_W = 64;
    localparam int TAG_W   = ENTRY_W - 1;
    localparam int REG_AW  = 8;
    localparam int REG_DW  = 8;

    // register offsets
    localparam logic [REG_AW-1:0] OFS_IRQ_STAT = 8'h30;
    localparam logic [REG_AW-1:0] OFS_IRQ_MASK = 8'h34;
    localparam logic [REG_AW-1:0] OFS_DB_STAT  = 8'h9C;
    localparam logic [REG_AW-1:0] OFS_DB_CLR   = 8'hA0;

    localparam logic [REG_DW-1:0] MASK_RESET   = 8'h05;
    localparam int                MASK_GATE_B  = 2;
    localparam logic [REG_DW-1:0] STAT_ACTIVE  = 8'h04;
endpackage

// File: rtl/cplq_slot_ptr.sv
module cplq_slot_ptr #(
    parameter int SLOTS = 1024,
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [IDX_W-1:0] slot_idx,
    output logic             phase
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(SLOTS - 1);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             ph;
    } ptr_t;

    ptr_t ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (adv) begin
            if (ptr_q.idx == LAST) begin
                ptr_d.idx = '0;
                ptr_d.ph  = ~ptr_q.ph;
            end else begin
                ptr_d.idx = ptr_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q.idx <= '0;
            ptr_q.ph  <= 1'b1;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    assign slot_idx = ptr_q.idx;
    assign phase    = ptr_q.ph;

    assert_wrap_flip_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && ptr_q.idx == LAST) |=> (ptr_q.idx == '0) && (ptr_q.ph != $past(ptr_q.ph)))
        else $error("wrap did not invert phase");
endmodule

// File: rtl/cplq_credit.sv
module cplq_credit #(
    parameter int SLOTS = 1024,
    parameter int CNT_W = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  logic give,
    output logic avail
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(SLOTS);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cred_t;

    cred_t cr_d, cr_q;

    always_comb begin
        cr_d = cr_q;
        unique case ({take, give})
            2'b10:   cr_d.cnt = cr_q.cnt - CNT_W'(1);
            2'b01:   cr_d.cnt = cr_q.cnt + CNT_W'(1);
            default: cr_d.cnt = cr_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cr_q.cnt <= FULL;
        else        cr_q <= cr_d;
    end

    assign avail = (cr_q.cnt != '0);

    assert_credit_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cr_q.cnt <= FULL)
        else $error("credit count above ring size");

    assert_no_take_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (cr_q.cnt != '0))
        else $error("tag taken with no free slot");
endmodule

// File: rtl/cplq_doorbell.sv
module cplq_doorbell
    import cplq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_evt,
    input  logic              msi_en,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    output logic              irq
);
    typedef struct packed {
        logic              pend;
        logic [REG_DW-1:0] mask;
    } db_t;

    db_t db_d, db_q;
    logic irq_en;
    logic clr_wr;

    assign irq_en = ~db_q.mask[MASK_GATE_B];
    assign clr_wr = reg_wr && (reg_addr == OFS_DB_CLR) && reg_wdata[0];
    assign irq    = db_q.pend && irq_en;

    always_comb begin
        db_d = db_q;
        if (reg_wr && reg_addr == OFS_IRQ_MASK)
            db_d.mask = reg_wdata;
        // new completion dominates any clear
        if (set_evt)
            db_d.pend = 1'b1;
        else if (clr_wr)
            db_d.pend = 1'b0;
        else if (msi_en && db_q.pend && irq_en)
            db_d.pend = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            db_q.pend <= 1'b0;
            db_q.mask <= MASK_RESET;
        end else begin
            db_q <= db_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            unique case (reg_addr)
                OFS_IRQ_STAT: reg_rdata = (db_q.pend && irq_en) ? STAT_ACTIVE : '0;
                OFS_IRQ_MASK: reg_rdata = db_q.mask;
                OFS_DB_STAT:  reg_rdata = {{(REG_DW-1){1'b0}}, db_q.pend};
                default:      reg_rdata = '0;
            endcase
        end
    end

    assert_set_pend_R5: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> db_q.pend)
        else $error("entry write did not raise pending");

    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !set_evt) |=> !db_q.pend)
        else $error("doorbell clear ignored");

    assert_msi_autoclr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (msi_en && irq && !set_evt) |=> !db_q.pend)
        else $error("pending not auto-cleared after message");

    assert_masked_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFS_IRQ_MASK && reg_wdata[MASK_GATE_B]) |=> !irq)
        else $error("irq while masked");
endmodule

// File: rtl/cplq_ring_writer.sv
module cplq_ring_writer
    import cplq_pkg::*;
#(
    parameter int SLOTS  = 1024,
    parameter int ADDR_W = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              msi_en,
    input  logic [ADDR_W-1:0] ring_base,
    input  logic              cpl_valid,
    output logic              cpl_ready,
    input  logic [TAG_W-1:0]  cpl_tag,
    input  logic              credit_ret,
    output logic              mem_wvalid,
    input  logic              mem_wready,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [ENTRY_W-1:0] mem_wdata,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    output logic              irq
);
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam int CNT_W = $clog2(SLOTS + 1);
    localparam int PAD_W = ADDR_W - IDX_W - 3;

    typedef struct packed {
        logic               busy;
        logic [ADDR_W-1:0]  addr;
        logic [ENTRY_W-1:0] data;
    } wr_t;

    wr_t wr_d, wr_q;

    logic             tag_fire;
    logic             wr_fire;
    logic             credit_ok;
    logic [IDX_W-1:0] slot_idx;
    logic             phase;
    logic [ADDR_W-1:0] slot_ofs;

    assign wr_fire   = wr_q.busy && mem_wready;
    assign cpl_ready = credit_ok && (!wr_q.busy || mem_wready);
    assign tag_fire  = cpl_valid && cpl_ready;
    assign slot_ofs  = {{PAD_W{1'b0}}, slot_idx, 3'b000};

    cplq_slot_ptr #(.SLOTS(SLOTS), .IDX_W(IDX_W)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (tag_fire),
        .slot_idx (slot_idx),
        .phase    (phase)
    );

    cplq_credit #(.SLOTS(SLOTS), .CNT_W(CNT_W)) u_credit (
        .clk   (clk),
        .rst_n (rst_n),
        .take  (tag_fire),
        .give  (credit_ret),
        .avail (credit_ok)
    );

    cplq_doorbell u_db (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_evt   (wr_fire),
        .msi_en    (msi_en),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    always_comb begin
        wr_d = wr_q;
        if (tag_fire) begin
            wr_d.busy = 1'b1;
            wr_d.addr = ring_base + slot_ofs;
            wr_d.data = {cpl_tag, phase};
        end else if (wr_fire) begin
            wr_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q.busy <= 1'b0;
            wr_q.addr <= '0;
            wr_q.data <= '0;
        end else begin
            wr_q <= wr_d;
        end
    end

    assign mem_wvalid = wr_q.busy;
    assign mem_waddr  = wr_q.addr;
    assign mem_wdata  = wr_q.data;

    assert_entry_tag_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tag_fire |=> mem_wvalid && (mem_wdata[ENTRY_W-1:1] == $past(cpl_tag)))
        else $error("entry does not carry accepted tag");

    assert_hold_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wvalid && !mem_wready) |=> mem_wvalid && $stable(mem_wdata) && $stable(mem_waddr))
        else $error("write request changed while stalled");
endmodule

// File: tb/cplq_ring_writer_tb.sv
module cplq_ring_writer_tb;
    localparam int SLOTS  = 8;
    localparam int ADDR_W = 40;
    localparam logic [ADDR_W-1:0] BASE = 40'h00_0000_1000;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n, msi_en, cpl_valid, cpl_ready, credit_ret;
    logic [62:0] cpl_tag;
    logic mem_wvalid, mem_wready;
    logic [ADDR_W-1:0] mem_waddr;
    logic [63:0] mem_wdata;
    logic reg_wr, reg_rd, irq;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;

    cplq_ring_writer #(.SLOTS(SLOTS), .ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .msi_en(msi_en), .ring_base(BASE),
        .cpl_valid(cpl_valid), .cpl_ready(cpl_ready), .cpl_tag(cpl_tag),
        .credit_ret(credit_ret), .mem_wvalid(mem_wvalid), .mem_wready(mem_wready),
        .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    int n_cmp = 0;
    int n_bad = 0;
    logic [ADDR_W-1:0] exp_a[$];
    logic [63:0]       exp_d[$];
    int   exp_slot = 0;
    logic exp_ph   = 1'b1;

    int wr_mode = 0;       // 0 ready, 1 pattern, 2 held low
    int pat_cnt = 0;
    int auto_cr = 1;
    int manual_cr = 0;
    int irq_cnt = 0;
    logic prev_stall = 1'b0;
    logic [ADDR_W-1:0] prev_a;
    logic [63:0] prev_d;

    assign mem_wready = (wr_mode == 0) || (wr_mode == 1 && (pat_cnt % 3) != 0);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(negedge clk) pat_cnt <= pat_cnt + 1;

    // monitor: scoreboard pop, stall check, host credit return
    always @(negedge clk) begin
        #2;
        credit_ret = 1'b0;
        if (rst_n) begin
            if (prev_stall) begin
                chk("R4 valid held", {63'd0, mem_wvalid}, 64'd1);
                chk("R4 addr held", {24'd0, mem_waddr}, {24'd0, prev_a});
                chk("R4 data held", mem_wdata, prev_d);
            end
            prev_stall = mem_wvalid && !mem_wready;
            prev_a = mem_waddr;
            prev_d = mem_wdata;
            if (mem_wvalid && mem_wready) begin
                if (exp_a.size() == 0) begin
                    chk("R1 unexpected write", 64'd1, 64'd0);
                end else begin
                    chk("R2 slot address", {24'd0, mem_waddr}, {24'd0, exp_a.pop_front()});
                    chk("R1 R2 entry data", mem_wdata, exp_d.pop_front());
                end
                if (auto_cr != 0) credit_ret = 1'b1;
            end
            if (!credit_ret && manual_cr > 0) begin
                credit_ret = 1'b1;
                manual_cr--;
            end
        end
    end

    always @(negedge clk) begin
        #3;
        if (irq) irq_cnt++;
    end

    task automatic send(input logic [62:0] tag);
        @(negedge clk);
        cpl_valid = 1'b1;
        cpl_tag   = tag;
        forever begin
            #1;
            if (cpl_ready) break;
            @(negedge clk);
        end
        exp_a.push_back(BASE + ADDR_W'(exp_slot * 8));
        exp_d.push_back({tag, exp_ph});
        exp_slot++;
        if (exp_slot == SLOTS) begin
            exp_slot = 0;
            exp_ph   = ~exp_ph;
        end
        @(posedge clk);
        #1 cpl_valid = 1'b0;
    endtask

    task automatic drain();
        do @(negedge clk); while (exp_a.size() != 0 || mem_wvalid);
        repeat (3) @(negedge clk);
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        reg_rd = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        rst_n = 1'b0; msi_en = 1'b0; cpl_valid = 1'b0; cpl_tag = '0;
        reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
        credit_ret = 1'b0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R11 ready after reset", {63'd0, cpl_ready}, 64'd1);
        chk("R11 no write after reset", {63'd0, mem_wvalid}, 64'd0);
        chk("R11 irq low after reset", {63'd0, irq}, 64'd0);
        reg_read(8'h9C, rd); chk("R5 doorbell reset", {56'd0, rd}, 64'd0);
        reg_read(8'h34, rd); chk("R7 mask reset", {56'd0, rd}, 64'h05);
        reg_read(8'h30, rd); chk("R8 status reset", {56'd0, rd}, 64'd0);

        // basic completions, interrupt masked
        for (int i = 0; i < 3; i++) send(63'h1_0000 + 63'(i));
        drain();
        reg_read(8'h9C, rd); chk("R5 doorbell pending", {56'd0, rd}, 64'd1);
        chk("R7 masked irq low", {63'd0, irq}, 64'd0);
        reg_read(8'h30, rd); chk("R8 status masked", {56'd0, rd}, 64'd0);

        reg_write(8'h34, 8'h00);
        #1 chk("R7 enabled irq follows pending", {63'd0, irq}, 64'd1);
        reg_read(8'h30, rd); chk("R8 status active", {56'd0, rd}, 64'h04);

        reg_write(8'hA0, 8'h00);
        reg_read(8'h9C, rd); chk("R6 clear with bit0=0 ignored", {56'd0, rd}, 64'd1);
        reg_write(8'hA0, 8'h01);
        reg_read(8'h9C, rd); chk("R6 clear", {56'd0, rd}, 64'd0);
        #1 chk("R7 irq low after clear", {63'd0, irq}, 64'd0);

        // streaming with backpressure, several wraps
        wr_mode = 1;
        for (int i = 0; i < 20; i++)
            send({23'(i * 7 + 3), 40'h5A_A5C3_3C00 + 40'(i)});
        drain();
        wr_mode = 0;

        // credit exhaustion
        auto_cr = 0;
        for (int i = 0; i < SLOTS; i++) send(63'h2_0000 + 63'(i));
        drain();
        @(negedge clk);
        cpl_valid = 1'b1; cpl_tag = 63'h7777;
        for (int i = 0; i < 5; i++) begin
            #1 chk("R3 stall without credit", {63'd0, cpl_ready}, 64'd0);
            @(negedge clk);
        end
        cpl_valid = 1'b0;
        manual_cr = 1;
        send(63'h7777);
        drain();
        manual_cr = SLOTS;
        repeat (SLOTS + 4) @(negedge clk);
        auto_cr = 1;

        // set and clear in the same cycle
        reg_write(8'hA0, 8'h01);
        wr_mode = 2;
        send(63'h4242);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 8'hA0; reg_wdata = 8'h01;
        wr_mode = 0;
        @(negedge clk);
        reg_wr = 1'b0;
        reg_read(8'h9C, rd); chk("R10 set wins over clear", {56'd0, rd}, 64'd1);
        drain();
        reg_write(8'hA0, 8'h01);

        // message-signalled delivery
        msi_en = 1'b1;
        irq_cnt = 0;
        send(63'h5151);
        drain();
        chk("R9 single pulse", 64'(irq_cnt), 64'd1);
        reg_read(8'h9C, rd); chk("R9 auto clear", {56'd0, rd}, 64'd0);

        reg_write(8'h34, 8'h05);
        irq_cnt = 0;
        send(63'h5252);
        drain();
        chk("R7 masked no pulse", 64'(irq_cnt), 64'd0);
        reg_read(8'h9C, rd); chk("R9 pending kept while masked", {56'd0, rd}, 64'd1);
        reg_write(8'h34, 8'h00);
        repeat (3) @(negedge clk);
        chk("R9 pulse on unmask", 64'(irq_cnt), 64'd1);
        reg_read(8'h9C, rd); chk("R9 cleared after unmask pulse", {56'd0, rd}, 64'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule